// File: doc/BRIEF.md
# Interconnect BIST Response Analyzer Array

This block checks a set of routing nets for faults by driving a short test sequence into them and comparing what comes back. The nets are organised as M net-sets of T tracks each. A single on-block pattern source places the same 2-bit vector on every compared pair at once: within a pair, one net carries the low bit and the other carries the high bit.

The returning far-end values are judged by an array of 2-input XOR comparators. One comparator watches each pair of neighbouring nets inside a set. Another comparator watches each pair of nets that share a track index in consecutive sets, which is how shorts between sets are caught. Each comparator keeps a sticky fail bit across the session, which forms its gross syndrome. When the session finishes, the whole syndrome vector can be read in parallel, or shifted out one bit at a time.

The routing fabric and the faults themselves live outside this block. The net input carries whatever comes back from the wires.

Top module: `ic_resp_grid`

## Requirements
- R1: After reset, `syndrome` is all zero, `done` is low and `drv_out` is all zero.
- R2: After the clock edge that samples `start`, `drv_out` carries vector 00, then 01, then 10, one cycle each, and then returns to zero. Net bit s*T+j carries the vector's low bit when s+j is even and its high bit when s+j is odd.
- R3: A vector's response is sampled from `net_in` in the cycle after that vector was driven. A comparator fails on a vector when the XOR of its two received nets differs from the XOR of the two bits it was driven with: 0 for vector 00 and 1 for vectors 01 and 10.
- R4: Syndrome bit s*(T-1)+j belongs to the comparator on nets j and j+1 of set s.
- R5: Syndrome bit M*(T-1)+s*T+j belongs to the comparator on net j of set s and net j of set s+1.
- R6: A syndrome bit, once set, stays set for the rest of the session, so it reports a fail if any of the three vectors miscompared.
- R7: `start` clears every syndrome bit on its sampling edge and restarts the sequence, even in the middle of a session.
- R8: `done` rises five cycles after the edge that samples `start`, and stays high until the next `start`.
- R9: While `done` is high, each cycle with `shift_en` high shifts the syndrome one place toward bit 0 and fills the top bit with zero. `ser_out` always shows syndrome bit 0.
- R10: `shift_en` has no effect while a session is running.
- R11: `net_in` has no effect outside the three sampling cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Session start strobe |
| shift_en | input | 1 | Serial readout shift enable |
| net_in | input | M*T | Far-end net values, net j of set s at bit s*T+j |
| drv_out | output | M*T | Near-end drive of the test vectors |
| done | output | 1 | Session complete |
| ser_out | output | 1 | Serial syndrome bit |
| syndrome | output | M*(T-1)+(M-1)*T | Gross syndrome, one bit per comparator |

## Verification
The bench builds the block at its default of three net-sets with sixteen tracks, which gives 77 comparators. This size is needed to reach the middle set: each of its nets sits in up to two neighbour comparators and two cross-set comparators. It also covers the edge tracks 0 and 15, where a net has only one in-set neighbour. Random sparse fault masks, applied independently on each of the three vectors, check the sticky accumulation against a bench model. Directed faults on single nets pin the bit positions of both comparator families.

// File: rtl/ic_resp_grid.sv
module ic_resp_grid #(
  parameter int M = 3,
  parameter int T = 16,
  localparam int NN = M * T,
  localparam int K = M * (T - 1) + (M - 1) * T
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          shift_en,
  input  logic [NN-1:0] net_in,
  output logic [NN-1:0] drv_out,
  output logic          done,
  output logic          ser_out,
  output logic [K-1:0]  syndrome
);
  localparam int KI = M * (T - 1);

  logic [2:0]   ph;
  logic [1:0]   vec;
  logic         ref_x;
  logic         smp;
  logic [K-1:0] miss;

  assign vec   = (ph == 3'd2) ? 2'b01 : (ph == 3'd3) ? 2'b10 : 2'b00;
  assign ref_x = (ph == 3'd3) || (ph == 3'd4);
  assign smp   = (ph >= 3'd2) && (ph <= 3'd4);
  assign done  = (ph == 3'd5);
  assign ser_out = syndrome[0];

  for (genvar s = 0; s < M; s++) begin : g_set
    for (genvar j = 0; j < T; j++) begin : g_drv
      assign drv_out[s*T+j] = vec[(s+j)%2];
    end
    for (genvar j = 0; j < T - 1; j++) begin : g_intra
      assign miss[s*(T-1)+j] = net_in[s*T+j] ^ net_in[s*T+j+1] ^ ref_x;
    end
  end

  for (genvar s = 0; s < M - 1; s++) begin : g_cross
    for (genvar j = 0; j < T; j++) begin : g_inter
      assign miss[KI+s*T+j] = net_in[s*T+j] ^ net_in[(s+1)*T+j] ^ ref_x;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= 3'd0;
      syndrome <= '0;
    end else if (start) begin
      ph       <= 3'd1;
      syndrome <= '0;
    end else begin
      if (ph != 3'd0 && ph != 3'd5) ph <= ph + 3'd1;
      if (smp) syndrome <= syndrome | miss;
      else if (done && shift_en) syndrome <= syndrome >> 1;
    end
  end

  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (syndrome == '0 && !done));

  a_r2_first_vector_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (drv_out == '0));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(done && shift_en)) |=> ((syndrome & $past(syndrome)) == $past(syndrome)));

  a_r8_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start, 5));

  a_r11_frozen_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && !shift_en) |=> $stable(syndrome));
endmodule

// File: tb/ic_resp_grid_test.sv
module ic_resp_grid_test;
  localparam int M = 3;
  localparam int T = 16;
  localparam int NN = M * T;
  localparam int K = M * (T - 1) + (M - 1) * T;
  localparam int KI = M * (T - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic shift_en = 1'b0;
  logic [NN-1:0] net_in = '0;
  logic [NN-1:0] drv_out;
  logic done, ser_out;
  logic [K-1:0] syndrome;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ic_resp_grid #(.M(M), .T(T)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .shift_en(shift_en),
    .net_in(net_in), .drv_out(drv_out), .done(done), .ser_out(ser_out),
    .syndrome(syndrome)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NN-1:0] pat(input int v);
    logic [NN-1:0] p;
    p = '0;
    for (int s = 0; s < M; s++)
      for (int j = 0; j < T; j++)
        p[s*T+j] = (v == 1) ? ((s + j) % 2 == 0) : (v == 2) ? ((s + j) % 2 == 1) : 1'b0;
    return p;
  endfunction

  function automatic logic [K-1:0] model(input logic [NN-1:0] m0, m1, m2);
    logic [K-1:0] e;
    logic [NN-1:0] r;
    e = '0;
    for (int v = 0; v < 3; v++) begin
      r = pat(v) ^ ((v == 0) ? m0 : (v == 1) ? m1 : m2);
      for (int s = 0; s < M; s++)
        for (int j = 0; j < T - 1; j++)
          if ((r[s*T+j] ^ r[s*T+j+1]) != (v != 0)) e[s*(T-1)+j] = 1'b1;
      for (int s = 0; s < M - 1; s++)
        for (int j = 0; j < T; j++)
          if ((r[s*T+j] ^ r[(s+1)*T+j]) != (v != 0)) e[KI+s*T+j] = 1'b1;
    end
    return e;
  endfunction

  function automatic logic [NN-1:0] rnd_net();
    return NN'({$urandom, $urandom});
  endfunction

  task automatic run(input logic [NN-1:0] m0, m1, m2, input bit busy_shift, output logic [K-1:0] got);
    logic [K-1:0] e;
    e = model(m0, m1, m2);
    @(negedge clk); start = 1'b1; shift_en = busy_shift;
    @(posedge clk); @(negedge clk); start = 1'b0;
    check("R2 vector 00", 128'(drv_out), 128'(pat(0)));
    check("R7 cleared by start", 128'(syndrome), 128'(0));
    check("R8 done low while busy", 128'(done), 128'(0));
    net_in = rnd_net();
    @(posedge clk); @(negedge clk);
    check("R2 vector 01", 128'(drv_out), 128'(pat(1)));
    net_in = pat(0) ^ m0;
    @(posedge clk); @(negedge clk);
    check("R2 vector 10", 128'(drv_out), 128'(pat(2)));
    net_in = pat(1) ^ m1;
    @(posedge clk); @(negedge clk);
    check("R2 drive idle", 128'(drv_out), 128'(0));
    check("R8 done not early", 128'(done), 128'(0));
    net_in = pat(2) ^ m2; shift_en = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8 done after five", 128'(done), 128'(1));
    check(busy_shift ? "R10 shift ignored while busy" : "R3 R6 syndrome", 128'(syndrome), 128'(e));
    got = syndrome;
    net_in = rnd_net();
    @(posedge clk); @(negedge clk);
    check("R11 late net_in ignored", 128'(syndrome), 128'(e));
    check("R8 done held", 128'(done), 128'(1));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [K-1:0] got, e, sh;
    logic [NN-1:0] f;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset syndrome", 128'(syndrome), 128'(0));
    check("R1 reset done", 128'(done), 128'(0));
    check("R1 reset drive", 128'(drv_out), 128'(0));
    rst_n = 1'b1;

    run('0, '0, '0, 1'b0, got);

    f = '0; f[2*T+15] = 1'b1;
    run('0, f, '0, 1'b0, got);
    e = '0; e[2*(T-1)+14] = 1'b1; e[KI+T+15] = 1'b1;
    check("R4 R5 top edge net", 128'(got), 128'(e));

    f = '0; f[T+5] = 1'b1;
    run(f, '0, '0, 1'b0, got);
    e = '0; e[(T-1)+4] = 1'b1; e[(T-1)+5] = 1'b1; e[KI+5] = 1'b1; e[KI+T+5] = 1'b1;
    check("R4 R5 middle set net", 128'(got), 128'(e));

    f = '0; f[0] = 1'b1; f[T] = 1'b1;
    run('0, '0, f, 1'b0, got);
    e = '0; e[0] = 1'b1; e[T-1] = 1'b1; e[KI+T] = 1'b1;
    check("R5 short between sets 0 and 1", 128'(got), 128'(e));

    run('0, '0, ~NN'(0), 1'b0, got);
    run(rnd_net() & rnd_net(), '0, '0, 1'b1, got);

    @(negedge clk); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    @(posedge clk); @(negedge clk); net_in = ~pat(0);
    @(posedge clk); @(negedge clk); start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    check("R7 restart mid session", 128'(syndrome), 128'(0));
    check("R7 restart done low", 128'(done), 128'(0));
    repeat (5) @(posedge clk);

    f = '0; f[3] = 1'b1; f[2*T+7] = 1'b1;
    run(f, f, '0, 1'b0, got);
    sh = '0;
    for (int i = 0; i < K; i++) begin
      @(negedge clk);
      sh[i] = ser_out;
      shift_en = 1'b1;
      @(posedge clk);
    end
    @(negedge clk); shift_en = 1'b0;
    check("R9 serial readout", 128'(sh), 128'(got));
    check("R9 zero fill after shift", 128'(syndrome), 128'(0));

    for (int n = 0; n < 20; n++)
      run(rnd_net() & rnd_net() & rnd_net(), rnd_net() & rnd_net() & rnd_net(),
          rnd_net() & rnd_net() & rnd_net(), 1'b0, got);

    finish_run();
  end
endmodule